// File: doc/BRIEF.md
# Capture Input Noise Filter with Source Selection

This block is the front end of one capture channel in a timer. It picks the signal to watch from three candidates: the channel's own pin, the pin of the neighbouring channel, or an internal trigger line. The chosen signal is brought into the clock domain through a two-flop synchronizer. A digital noise filter then accepts a new level only when enough consecutive samples agree on it.

The filter has a 4-bit setting. This setting picks a sampling rate and a required run length N. The sampling rate is either the internal-clock strobe or the dead-time-clock strobe, divided by 1, 2, 4, 8, 16 or 32. Both clocks are modelled as enable strobes in the single system clock domain. The block drives the filtered level, plus single-cycle pulses for a rising or falling filtered edge, to the capture logic that follows it.

Top module: `cap_in_filter`

## Requirements
- R1: While reset is held and right after it is released, `level_o`, `rise_o` and `fall_o` are all low.
- R2: `src_sel_i` chooses the filtered source: 2'b01 own pin, 2'b10 neighbour pin, 2'b11 internal trigger, 2'b00 a constant low. The two sources that are not selected have no effect on the outputs.
- R3: With setting 4'b0000 the filter is bypassed (N = 1, one sample per dead-time strobe). When the dead-time strobe is high every cycle, a change of the selected input shows on `level_o` at the third rising clock edge after it.
- R4: Settings 4'b0001, 4'b0010 and 4'b0011 sample on the internal-clock strobe with N = 2, 4 and 8. While that strobe is low, `level_o` does not change.
- R5: The dead-time strobe is divided by 2 for settings 4'b0100/4'b0101 (N = 6/8), by 4 for 4'b0110/4'b0111 (N = 6/8), and by 8 for 4'b1000/4'b1001 (N = 6/8). It is divided by 16 for 4'b1010/4'b1011/4'b1100 (N = 5/6/8) and by 32 for 4'b1101/4'b1110/4'b1111 (N = 5/6/8).
- R6: A new level reaches `level_o` only on the N-th consecutive sample that shows it. A pulse that covers fewer than N samples is dropped.
- R7: A sample equal to the current filtered level clears the agreement count. Two short bursts separated by one such sample do not add up.
- R8: A change of the filter setting clears the agreement count and the divider phase. It leaves `level_o` as it was.
- R9: `rise_o` and `fall_o` each pulse for exactly one cycle, in the cycle in which `level_o` takes its new value. They are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dts_en_i | input | 1 | Dead-time clock strobe |
| int_en_i | input | 1 | Internal clock strobe |
| src_sel_i | input | 2 | Source select |
| flt_code_i | input | 4 | Filter setting |
| pin_own_i | input | 1 | Channel's own input pin |
| pin_nbr_i | input | 1 | Neighbouring channel's input pin |
| trig_i | input | 1 | Internal trigger input |
| level_o | output | 1 | Filtered level |
| rise_o | output | 1 | Rising edge pulse of the filtered level |
| fall_o | output | 1 | Falling edge pulse of the filtered level |

## Verification
The hardest case to reach is a filter setting change in the middle of a run. The change must land after some agreeing samples have been counted and before the run completes. The stimulus runs with N = 4 and the internal strobe held high. It moves the setting to N = 8 exactly two samples into a run. The new edge must then appear at the precise cycle that follows from a full restart of the count; a count that carried over would make it appear two cycles early.

The divided settings have a sampling phase that cannot be seen at the ports. Each step is therefore checked against a window bounded by the earliest and latest possible strobe. Glitches are sized to cover at most N-1 strobes in the worst phase.

// File: rtl/cif_pkg.sv
package cif_pkg;
  localparam int CODE_W = 4;
  localparam int RUN_W  = 4;
  localparam int DIVL_W = 3;

  typedef struct packed {
    logic              use_int;
    logic [DIVL_W-1:0] div_log2;
    logic [RUN_W-1:0]  run_len;
  } flt_cfg_t;

  function automatic flt_cfg_t decode_code(input logic [CODE_W-1:0] code);
    flt_cfg_t c;
    c.use_int = 1'b0;
    c.div_log2 = '0;
    c.run_len = RUN_W'(1);
    unique case (code)
      4'd0:  c.run_len = RUN_W'(1);
      4'd1:  begin c.use_int = 1'b1; c.run_len = RUN_W'(2); end
      4'd2:  begin c.use_int = 1'b1; c.run_len = RUN_W'(4); end
      4'd3:  begin c.use_int = 1'b1; c.run_len = RUN_W'(8); end
      4'd4:  begin c.div_log2 = 3'd1; c.run_len = RUN_W'(6); end
      4'd5:  begin c.div_log2 = 3'd1; c.run_len = RUN_W'(8); end
      4'd6:  begin c.div_log2 = 3'd2; c.run_len = RUN_W'(6); end
      4'd7:  begin c.div_log2 = 3'd2; c.run_len = RUN_W'(8); end
      4'd8:  begin c.div_log2 = 3'd3; c.run_len = RUN_W'(6); end
      4'd9:  begin c.div_log2 = 3'd3; c.run_len = RUN_W'(8); end
      4'd10: begin c.div_log2 = 3'd4; c.run_len = RUN_W'(5); end
      4'd11: begin c.div_log2 = 3'd4; c.run_len = RUN_W'(6); end
      4'd12: begin c.div_log2 = 3'd4; c.run_len = RUN_W'(8); end
      4'd13: begin c.div_log2 = 3'd5; c.run_len = RUN_W'(5); end
      4'd14: begin c.div_log2 = 3'd5; c.run_len = RUN_W'(6); end
      default: begin c.div_log2 = 3'd5; c.run_len = RUN_W'(8); end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/cif_src_sync.sv
module cif_src_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] sel_i,
  input  logic       own_i,
  input  logic       nbr_i,
  input  logic       trig_i,
  output logic       smp_o
);
  logic raw;
  logic [STAGES-1:0] sync_q;

  always_comb begin
    unique case (sel_i)
      2'b01:   raw = own_i;
      2'b10:   raw = nbr_i;
      2'b11:   raw = trig_i;
      default: raw = 1'b0;
    endcase
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= raw;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
    end
  end

  assign smp_o = sync_q[STAGES-1];
endmodule

// File: rtl/cif_strobe_gen.sv
module cif_strobe_gen #(
  parameter int PRE_W  = 5,
  parameter int DIVL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              dts_en_i,
  input  logic              int_en_i,
  input  logic              use_int_i,
  input  logic [DIVL_W-1:0] div_log2_i,
  output logic              stb_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] last;
  logic             hit;

  assign span = (PRE_W+1)'(1) << div_log2_i;
  assign last = PRE_W'(span - (PRE_W+1)'(1));
  assign hit  = dts_en_i && (pre_q == last);
  assign stb_o = !clr_i && (use_int_i ? int_en_i : hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pre_q <= '0;
    else if (clr_i)                 pre_q <= '0;
    else if (!use_int_i && dts_en_i) pre_q <= hit ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/cif_run_filter.sv
module cif_run_filter #(
  parameter int RUN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             smp_i,
  input  logic [RUN_W-1:0] run_len_i,
  output logic             level_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [RUN_W-1:0] cnt_q;
  logic [RUN_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + (RUN_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_o <= 1'b0;
      rise_o  <= 1'b0;
      fall_o  <= 1'b0;
    end else begin
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (stb_i) begin
        if (smp_i == level_o) begin
          cnt_q <= '0;  // agreeing with current level breaks the run
        end else if (cnt_nxt >= {1'b0, run_len_i}) begin
          cnt_q   <= '0;
          level_o <= smp_i;
          rise_o  <= smp_i;
          fall_o  <= !smp_i;
        end else begin
          cnt_q <= cnt_nxt[RUN_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/cap_in_filter.sv
module cap_in_filter
  import cif_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dts_en_i,
  input  logic              int_en_i,
  input  logic [1:0]        src_sel_i,
  input  logic [CODE_W-1:0] flt_code_i,
  input  logic              pin_own_i,
  input  logic              pin_nbr_i,
  input  logic              trig_i,
  output logic              level_o,
  output logic              rise_o,
  output logic              fall_o
);
  logic [CODE_W-1:0] code_q;
  logic              code_chg;
  flt_cfg_t          cfg;
  logic              smp;
  logic              stb;

  assign cfg      = decode_code(flt_code_i);
  assign code_chg = (flt_code_i != code_q);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) code_q <= '0;
    else         code_q <= flt_code_i;

  cif_src_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (src_sel_i),
    .own_i  (pin_own_i),
    .nbr_i  (pin_nbr_i),
    .trig_i (trig_i),
    .smp_o  (smp)
  );

  cif_strobe_gen #(.PRE_W(PRE_W), .DIVL_W(DIVL_W)) u_stb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (code_chg),
    .dts_en_i   (dts_en_i),
    .int_en_i   (int_en_i),
    .use_int_i  (cfg.use_int),
    .div_log2_i (cfg.div_log2),
    .stb_o      (stb)
  );

  cif_run_filter #(.RUN_W(RUN_W)) u_flt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (code_chg),
    .stb_i     (stb),
    .smp_i     (smp),
    .run_len_i (cfg.run_len),
    .level_o   (level_o),
    .rise_o    (rise_o),
    .fall_o    (fall_o)
  );
endmodule

// File: rtl/cap_in_filter_chk.sv
module cap_in_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_en_i,
  input logic [3:0] flt_code_i,
  input logic [3:0] code_q_i,
  input logic       level_o,
  input logic       rise_o,
  input logic       fall_o
);
  a_r9_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));

  a_r9_rise_marks_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level_o) |-> rise_o);

  a_r9_fall_marks_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(level_o) |-> fall_o);

  a_r9_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  a_r9_rise_level_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> level_o);

  a_r8_code_change_keeps_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_code_i != code_q_i) |=> $stable(level_o));

  a_r4_no_int_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!int_en_i && flt_code_i inside {4'd1, 4'd2, 4'd3} && flt_code_i == code_q_i)
      |=> $stable(level_o));

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_quiet: assert (!level_o && !rise_o && !fall_o);
endmodule

bind cap_in_filter cap_in_filter_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .int_en_i   (int_en_i),
  .flt_code_i (flt_code_i),
  .code_q_i   (code_q),
  .level_o    (level_o),
  .rise_o     (rise_o),
  .fall_o     (fall_o)
);

// File: tb/cap_in_filter_test.sv
module cap_in_filter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dts_en = 1'b1, int_en = 1'b1;
  logic [1:0] src = 2'b01;
  logic [3:0] code = 4'd0;
  logic       own = 1'b0, nbr = 1'b0, trig = 1'b0;
  logic       level, rise, fall;

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { bit up; int lo; int hi; string tag; } exp_t;
  exp_t exp_q[$];
  exp_t cur;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_in_filter uut (
    .clk_i(clk), .rst_ni(rst_n), .dts_en_i(dts_en), .int_en_i(int_en),
    .src_sel_i(src), .flt_code_i(code), .pin_own_i(own), .pin_nbr_i(nbr),
    .trig_i(trig), .level_o(level), .rise_o(rise), .fall_o(fall)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int run_n(int c);
    case (c)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4, 6, 8: return 6;  10, 13: return 5;  11, 14: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int div_d(int c);
    if (c < 4) return 1;
    if (c < 6) return 2;
    if (c < 8) return 4;
    if (c < 10) return 8;
    if (c < 13) return 16;
    return 32;
  endfunction

  // monitor: pop and compare each observed edge
  always @(negedge clk) begin
    if (rst_n && (rise || fall)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected edge at cycle", cyc, -1);
      end else begin
        cur = exp_q.pop_front();
        check(rise == cur.up && rise != fall, cur.tag, "edge kind rise", int'(rise), int'(cur.up));
        check(cyc >= cur.lo && cyc <= cur.hi, cur.tag, "edge cycle", cyc, cur.lo);
      end
    end
  end

  task automatic set_in(bit v);
    case (src)
      2'b01: own = v;
      2'b10: nbr = v;
      default: trig = v;
    endcase
  endtask

  task automatic push(bit up, int lo, int hi, string tag);
    exp_t e;
    e.up = up; e.lo = lo; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // drive a step and queue the expected edge window
  task automatic step(bit v, int c, string tag);
    int e0, n, d;
    @(negedge clk);
    set_in(v);
    e0 = cyc; n = run_n(c); d = div_d(c);
    push(v, e0 + 3 + (n - 1) * d, e0 + 2 + n * d, tag);
  endtask

  task automatic drain(int cycles, string tag);
    repeat (cycles) @(negedge clk);
    check(exp_q.size() == 0, tag, "missing edges", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic set_code(logic [3:0] c);
    @(negedge clk);
    code = c;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(level == 1'b0, "R1", "level in reset", level, 0);
    check(rise == 1'b0 && fall == 1'b0, "R1", "pulses in reset", rise | fall, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!level && !rise && !fall, "R1", "after reset", level | rise | fall, 0);

    // R3 bypass, R2 own pin
    step(1'b1, 0, "R3");
    drain(8, "R3");
    check(level == 1'b1, "R3", "level after rise", level, 1);
    step(1'b0, 0, "R3");
    drain(8, "R3");

    // R2 neighbour selected, own pin ignored
    @(negedge clk); src = 2'b10;
    @(negedge clk); own = 1'b1;
    repeat (10) @(negedge clk);
    check(level == 1'b0, "R2", "own pin ignored", level, 0);
    own = 1'b0;
    step(1'b1, 0, "R2");
    drain(8, "R2");
    @(negedge clk); trig = 1'b1;
    repeat (8) @(negedge clk);
    check(level == 1'b1, "R2", "trigger ignored", level, 1);
    trig = 1'b0;
    step(1'b0, 0, "R2");
    drain(8, "R2");

    // R2 trigger source, then constant-low source
    @(negedge clk); src = 2'b11;
    step(1'b1, 0, "R2");
    drain(8, "R2");
    begin
      int e0;
      @(negedge clk); src = 2'b00; e0 = cyc;
      push(1'b0, e0 + 3, e0 + 3, "R2");
    end
    drain(8, "R2");
    @(negedge clk); trig = 1'b0; src = 2'b01;
    repeat (4) @(negedge clk);

    // R4 R5 R6 sweep all filtered settings: step, step, glitch
    for (int c = 1; c < 16; c++) begin
      int n, d, w;
      n = run_n(c); d = div_d(c);
      set_code(4'(c));
      step(1'b1, c, (c < 4) ? "R4" : "R5");
      drain(n * d + 8, "R5");
      check(level == 1'b1, "R5", "level high after run", level, 1);
      step(1'b0, c, (c < 4) ? "R4" : "R5");
      drain(n * d + 8, "R5");
      w = (n - 2) * d + 1;
      @(negedge clk); own = 1'b1;
      repeat (w) @(negedge clk);
      own = 1'b0;
      repeat (n * d + 8) @(negedge clk);
      check(level == 1'b0, "R6", "short pulse rejected", level, 0);
    end

    // R7 two bursts of N-1 split by one agreeing sample
    set_code(4'd2);
    @(negedge clk); own = 1'b1;
    repeat (3) @(negedge clk); own = 1'b0;
    @(negedge clk); own = 1'b1;
    repeat (3) @(negedge clk); own = 1'b0;
    repeat (12) @(negedge clk);
    check(level == 1'b0, "R7", "split bursts rejected", level, 0);

    // R8 setting change two samples into a run restarts the count
    begin
      int e0;
      @(negedge clk); own = 1'b1; e0 = cyc;
      push(1'b1, e0 + 13, e0 + 13, "R8");
      repeat (4) @(negedge clk);
      code = 4'd3;
    end
    drain(20, "R8");
    @(negedge clk); code = 4'd15;
    repeat (6) @(negedge clk);
    check(level == 1'b1, "R8", "level kept over change", level, 1);
    set_code(4'd0);
    step(1'b0, 0, "R8");
    drain(8, "R8");

    // R4 no internal strobe, no sampling
    @(negedge clk); code = 4'd1; int_en = 1'b0;
    repeat (2) @(negedge clk);
    own = 1'b1;
    repeat (20) @(negedge clk);
    check(level == 1'b0, "R4", "held without strobe", level, 0);
    begin
      int e1;
      int_en = 1'b1; e1 = cyc;
      push(1'b1, e1 + 2, e1 + 2, "R4");
    end
    drain(8, "R4");
    step(1'b0, 1, "R4");
    drain(8, "R4");
    check(level == 1'b0, "R9", "final level", level, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule